// File: doc/BRIEF.md
# DMA Pipe Interrupt Aggregator

This block collects interrupt events from a set of DMA pipes and from the shared controller logic. It turns them into one level-sensitive interrupt line for a single execution environment. Each pipe keeps a six-bit sticky status word, a per-pipe enable word and a write-one-to-clear port. The enabled pipe bits are folded into one summary source word, with one bit per pipe in the low positions and the controller's own events in the top bit. The controller events are error, empty, timer and bus response error. They have their own status, enable and clear registers.

A final per-environment mask decides which source bits may raise the output line. Software reads the source word to find the pipes that need service. It then reads and clears each pipe's status. The line drops once every unmasked, enabled status bit has been cleared. Register reads are combinational from a flat word address. Writes take effect at the next clock edge.

Top module: `dmairq_aggr`

## Requirements
- R1: After reset, every pipe status, the controller status, the controller enable, the mask and the source word read 0. Every pipe enable reads 0x31 (processed-descriptor, error and transfer-end enabled), and `irq_out` is low.
- R2: A one on bit b of a pipe's event strobe (`pipe_evt[6*p+b]`) sets status bit b of pipe p at the next edge, whether or not that bit is enabled. The bit meanings are: 0 processed descriptor, 1 timer, 2 wake, 3 out of descriptors, 4 error, 5 transfer end.
- R3: Writing to a pipe's clear address (base 0x20 + 4*p + 2) clears the status bits written as one and leaves the bits written as zero unchanged. A pipe's status reads at 0x20 + 4*p and its enable at 0x20 + 4*p + 1.
- R4: When a set strobe and a clear write hit the same status bit in the same cycle, the bit ends up set. This holds for both pipe and controller status.
- R5: Source bit p (address 0x00) is one exactly when pipe p has a status bit that is both set and enabled. A set but disabled status bit does not contribute.
- R6: Source bit 31 is one exactly when a controller status bit is both set and enabled. Source bits from the pipe count up to 30 always read 0.
- R7: The controller event strobe `glb_evt[3:0]` sets controller status bits 1 (bus response error), 2 (error), 3 (empty) and 4 (timer) respectively. Status reads at 0x02, enable at 0x03, write-one-to-clear at 0x04, and bit 0 and bits 5 and up read 0.
- R8: `irq_out` is high exactly when some source bit is one and its bit in the mask (read/write at 0x01) is one. A zero mask holds the line low.
- R9: `irq_out` is a level. It stays high with no further events until the status bits behind it are cleared or disabled.
- R10: Enable registers keep only their defined bits: six bits for a pipe, bits 1 to 4 for the controller. The other bits read 0.
- R11: Writes to read-only addresses (source, status) and to unmapped addresses change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Word address for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| pipe_evt | input | 6*NUM_PIPES | Per-pipe event strobes, six per pipe |
| glb_evt | input | 4 | Controller event strobes |
| irq_out | output | 1 | Level interrupt to the execution environment |

## Verification
Events and register writes are sampled at a clock edge and become visible one edge later. Because reads and `irq_out` are combinational from the registers, a result is due in the cycle right after its stimulus. The bench drives each stimulus just after a rising edge and queues the expected read value and line level for that cycle. A monitor then compares them at the falling edge of the same cycle. This means every check lands exactly one edge after the stimulus it depends on, including the same-cycle set-and-clear cases.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;
   localparam int DATA_W      = 32;
   localparam int PSTAT_W     = 6;
   localparam int GEVT_W      = 4;
   localparam int GSTAT_LSB   = 1;
   localparam int SRC_GLB_BIT = 31;
   localparam int MAX_PIPES   = 31;

   localparam logic [PSTAT_W-1:0] PEN_RESET = 6'b110001;

   localparam int A_SRC   = 'h00;
   localparam int A_MASK  = 'h01;
   localparam int A_GSTAT = 'h02;
   localparam int A_GEN   = 'h03;
   localparam int A_GCLR  = 'h04;

   localparam int PIPE_BASE   = 'h20;
   localparam int PIPE_STRIDE = 4;

   typedef enum int {
      POFF_STAT = 0,
      POFF_EN   = 1,
      POFF_CLR  = 2
   } poff_e;

   function automatic int pipe_addr(input int p, input poff_e off);
      return PIPE_BASE + p * PIPE_STRIDE + int'(off);
   endfunction
endpackage

// File: rtl/dmairq_pipe_bank.sv
module dmairq_pipe_bank
   import dmairq_pkg::*;
#(
   parameter int NUM_PIPES = 4,
   parameter int ADDR_W    = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [ADDR_W-1:0]            wr_addr,
   input  logic [DATA_W-1:0]            wr_data,
   input  logic [NUM_PIPES*PSTAT_W-1:0] evt,
   output logic [NUM_PIPES*PSTAT_W-1:0] stat,
   output logic [NUM_PIPES*PSTAT_W-1:0] en,
   output logic [NUM_PIPES-1:0]         src
);
   localparam int STAT_BITS = NUM_PIPES * PSTAT_W;

   initial begin
      if (STAT_BITS != NUM_PIPES * PSTAT_W) $error("pipe bank width mismatch");
   end

   for (genvar p = 0; p < NUM_PIPES; p++) begin : g_pipe
      localparam logic [ADDR_W-1:0] EN_A  = ADDR_W'(pipe_addr(p, POFF_EN));
      localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(pipe_addr(p, POFF_CLR));

      logic [PSTAT_W-1:0] st_q, en_q, clr_bits;
      logic               en_wr;

      assign en_wr    = wr_en && (wr_addr == EN_A);
      assign clr_bits = (wr_en && (wr_addr == CLR_A)) ? wr_data[PSTAT_W-1:0] : '0;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            st_q <= '0;
            en_q <= PEN_RESET;
         end else begin
            st_q <= (st_q & ~clr_bits) | evt[p*PSTAT_W +: PSTAT_W];
            if (en_wr) en_q <= wr_data[PSTAT_W-1:0];
         end
      end

      assign stat[p*PSTAT_W +: PSTAT_W] = st_q;
      assign en[p*PSTAT_W +: PSTAT_W]   = en_q;
      assign src[p]                     = |(st_q & en_q);
   end
endmodule

// File: rtl/dmairq_glb_unit.sv
module dmairq_glb_unit
   import dmairq_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [GEVT_W-1:0] evt,
   output logic [GEVT_W-1:0] stat,
   output logic [GEVT_W-1:0] en,
   output logic              src
);
   localparam logic [ADDR_W-1:0] EN_A  = ADDR_W'(A_GEN);
   localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(A_GCLR);
   localparam int               MSB   = GSTAT_LSB + GEVT_W - 1;

   logic [GEVT_W-1:0] clr_bits;

   assign clr_bits = (wr_en && (wr_addr == CLR_A)) ? wr_data[MSB:GSTAT_LSB] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat <= '0;
         en   <= '0;
      end else begin
         stat <= (stat & ~clr_bits) | evt;
         if (wr_en && (wr_addr == EN_A)) en <= wr_data[MSB:GSTAT_LSB];
      end
   end

   assign src = |(stat & en);
endmodule

// File: rtl/dmairq_aggr.sv
module dmairq_aggr
   import dmairq_pkg::*;
#(
   parameter int NUM_PIPES = 4,
   parameter int ADDR_W    = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         reg_we,
   input  logic [ADDR_W-1:0]            reg_addr,
   input  logic [DATA_W-1:0]            reg_wdata,
   output logic [DATA_W-1:0]            reg_rdata,
   input  logic [NUM_PIPES*PSTAT_W-1:0] pipe_evt,
   input  logic [GEVT_W-1:0]            glb_evt,
   output logic                         irq_out
);
   localparam int PAD_W    = SRC_GLB_BIT - NUM_PIPES;
   localparam int MAP_END  = PIPE_BASE + NUM_PIPES * PIPE_STRIDE;

   if (NUM_PIPES < 1 || NUM_PIPES > MAX_PIPES) begin : g_bad_pipes
      initial $error("NUM_PIPES must be 1..31");
   end
   if (MAP_END > (1 << ADDR_W)) begin : g_bad_addr
      initial $error("ADDR_W too small for the pipe register window");
   end

   logic [NUM_PIPES*PSTAT_W-1:0] pipe_stat, pipe_en;
   logic [NUM_PIPES-1:0]         pipe_src;
   logic [GEVT_W-1:0]            glb_stat, glb_en;
   logic                         glb_src;
   logic [DATA_W-1:0]            src_word, env_mask;

   dmairq_pipe_bank #(.NUM_PIPES(NUM_PIPES), .ADDR_W(ADDR_W)) u_pipes (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (reg_we),
      .wr_addr (reg_addr),
      .wr_data (reg_wdata),
      .evt     (pipe_evt),
      .stat    (pipe_stat),
      .en      (pipe_en),
      .src     (pipe_src)
   );

   dmairq_glb_unit #(.ADDR_W(ADDR_W)) u_glb (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (reg_we),
      .wr_addr (reg_addr),
      .wr_data (reg_wdata),
      .evt     (glb_evt),
      .stat    (glb_stat),
      .en      (glb_en),
      .src     (glb_src)
   );

   if (PAD_W > 0) begin : g_src_pad
      assign src_word = {glb_src, {PAD_W{1'b0}}, pipe_src};
   end else begin : g_src_full
      assign src_word = {glb_src, pipe_src};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                      env_mask <= '0;
      else if (reg_we && reg_addr == ADDR_W'(A_MASK))  env_mask <= reg_wdata;
   end

   assign irq_out = |(src_word & env_mask);

   always_comb begin
      reg_rdata = '0;
      if      (reg_addr == ADDR_W'(A_SRC))   reg_rdata = src_word;
      else if (reg_addr == ADDR_W'(A_MASK))  reg_rdata = env_mask;
      else if (reg_addr == ADDR_W'(A_GSTAT)) reg_rdata = DATA_W'({glb_stat, 1'b0});
      else if (reg_addr == ADDR_W'(A_GEN))   reg_rdata = DATA_W'({glb_en, 1'b0});
      for (int p = 0; p < NUM_PIPES; p++) begin
         if (reg_addr == ADDR_W'(pipe_addr(p, POFF_STAT)))
            reg_rdata = DATA_W'(pipe_stat[p*PSTAT_W +: PSTAT_W]);
         if (reg_addr == ADDR_W'(pipe_addr(p, POFF_EN)))
            reg_rdata = DATA_W'(pipe_en[p*PSTAT_W +: PSTAT_W]);
      end
   end
endmodule

// File: rtl/dmairq_aggr_chk.sv
module dmairq_aggr_chk
   import dmairq_pkg::*;
#(
   parameter int NUM_PIPES = 4
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         reg_we,
   input logic [NUM_PIPES*PSTAT_W-1:0] pipe_evt,
   input logic [GEVT_W-1:0]            glb_evt,
   input logic [NUM_PIPES*PSTAT_W-1:0] pipe_stat,
   input logic [GEVT_W-1:0]            glb_stat,
   input logic [DATA_W-1:0]            env_mask,
   input logic                         irq_out
);
   a_r2_evt_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (|pipe_evt) |=> ((pipe_stat & $past(pipe_evt)) == $past(pipe_evt)));

   a_r3_pipe_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_we |=> ((pipe_stat & $past(pipe_stat)) == $past(pipe_stat)));

   a_r7_glb_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_we |=> ((glb_stat & $past(glb_stat)) == $past(glb_stat)));

   a_r4_glb_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (|glb_evt) |=> ((glb_stat & $past(glb_evt)) == $past(glb_evt)));

   a_r8_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (env_mask == '0) |-> !irq_out);

   a_r9_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_out && !reg_we) |=> irq_out);
endmodule

bind dmairq_aggr dmairq_aggr_chk #(.NUM_PIPES(NUM_PIPES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_we    (reg_we),
   .pipe_evt  (pipe_evt),
   .glb_evt   (glb_evt),
   .pipe_stat (pipe_stat),
   .glb_stat  (glb_stat),
   .env_mask  (env_mask),
   .irq_out   (irq_out)
);

// File: tb/dmairq_aggr_bench.sv
`timescale 1ns/1ps
module dmairq_aggr_bench;
   localparam int NP = 4;
   localparam int AW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_we = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic [NP*6-1:0] pipe_evt = '0;
   logic [3:0]    glb_evt = '0;
   logic          irq_out;

   int checks = 0;
   int errors = 0;

   typedef struct {
      logic [AW-1:0] addr;
      logic [31:0]   data;
      int            irq;
      string         tag;
   } item_t;
   item_t sb[$];

   always #10 clk = ~clk;

   dmairq_aggr #(.NUM_PIPES(NP), .ADDR_W(AW)) u_dmairq_aggr (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pipe_evt(pipe_evt),
      .glb_evt(glb_evt), .irq_out(irq_out)
   );

   // monitor: compares queued expectations at the falling edge
   always @(negedge clk) begin
      if (sb.size() > 0) begin
         item_t it;
         it = sb.pop_front();
         checks++;
         if (reg_rdata !== it.data) begin
            errors++;
            $display("FAIL %s addr=0x%02h actual=0x%08h expected=0x%08h",
                     it.tag, it.addr, reg_rdata, it.data);
         end
         if (it.irq >= 0) begin
            checks++;
            if (irq_out !== it.irq[0]) begin
               errors++;
               $display("FAIL %s irq actual=%0b expected=%0d", it.tag, irq_out, it.irq);
            end
         end
      end
   end

   task automatic drive(input logic we, input int addr, input logic [31:0] data,
                        input logic [NP*6-1:0] pe, input logic [3:0] ge);
      @(posedge clk);
      #2;
      reg_we    = we;
      reg_addr  = AW'(addr);
      reg_wdata = data;
      pipe_evt  = pe;
      glb_evt   = ge;
   endtask

   task automatic wr(input int addr, input logic [31:0] data);
      drive(1'b1, addr, data, '0, '0);
   endtask

   task automatic chk(input int addr, input logic [31:0] exp, input int irq, input string tag);
      item_t it;
      drive(1'b0, addr, 32'h0, '0, '0);
      it.addr = AW'(addr);
      it.data = exp;
      it.irq  = irq;
      it.tag  = tag;
      sb.push_back(it);
   endtask

   function automatic logic [NP*6-1:0] pev(input int p, input logic [5:0] bits);
      return (NP*6)'(bits) << (6 * p);
   endfunction

   function automatic int pa(input int p, input int off);
      return 'h20 + 4 * p + off;
   endfunction

   initial begin
      #(200000 * 20);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;

      // R1 reset state
      chk('h00, 32'h0, 0, "R1 src");
      chk('h01, 32'h0, 0, "R1 mask");
      chk('h02, 32'h0, 0, "R1 gstat");
      chk('h03, 32'h0, 0, "R1 gen");
      chk(pa(0,1), 32'h31, 0, "R1 p0 en");
      chk(pa(3,1), 32'h31, 0, "R1 p3 en");
      chk(pa(2,0), 32'h0, 0, "R1 p2 stat");

      // R2 / R5 processed descriptor on pipe 1
      drive(1'b0, 0, 0, pev(1, 6'h01), '0);
      chk(pa(1,0), 32'h1, 0, "R2 p1 stat");
      chk('h00, 32'h2, 0, "R5 src p1");
      // R2 wake on pipe 2 is disabled by default
      drive(1'b0, 0, 0, pev(2, 6'h04), '0);
      chk(pa(2,0), 32'h4, 0, "R2 p2 wake set");
      chk('h00, 32'h2, 0, "R5 disabled no contribute");

      // R8 unmask
      wr('h01, 32'hFFFF_FFFF);
      chk('h00, 32'h2, 1, "R8 mask open");
      repeat (3) drive(1'b0, 0, 0, '0, '0);
      chk('h00, 32'h2, 1, "R9 level held");

      // R3 clear
      wr(pa(1,2), 32'h3E);
      chk(pa(1,0), 32'h1, 1, "R3 zero bits keep");
      wr(pa(1,2), 32'h01);
      chk(pa(1,0), 32'h0, 0, "R3 cleared");
      chk('h00, 32'h0, 0, "R9 drop after clear");

      // R10 pipe enable
      wr(pa(2,1), 32'h04);
      chk(pa(2,1), 32'h04, 1, "R10 p2 en");
      chk('h00, 32'h4, 1, "R5 src p2");
      wr(pa(2,1), 32'hFFFF_FFFF);
      chk(pa(2,1), 32'h3F, 1, "R10 p2 en width");

      // R4 set wins (pipe)
      drive(1'b1, pa(2,2), 32'h04, pev(2, 6'h04), '0);
      chk(pa(2,0), 32'h4, 1, "R4 pipe set wins");
      wr(pa(2,2), 32'h3F);
      chk(pa(2,0), 32'h0, 0, "R3 p2 cleared");

      // R7 / R6 controller
      drive(1'b0, 0, 0, '0, 4'b0101);
      chk('h02, 32'h0A, 0, "R7 gstat");
      chk('h00, 32'h0, 0, "R6 disabled");
      wr('h03, 32'h04);
      chk('h00, 32'h0, 0, "R6 other bit enabled");
      wr('h03, 32'h08);
      chk('h03, 32'h08, 1, "R10 gen");
      chk('h00, 32'h8000_0000, 1, "R6 src top");
      wr('h03, 32'hFFFF_FFFF);
      chk('h03, 32'h1E, 1, "R10 gen width");

      // R8 mask gates top bit
      wr('h01, 32'h7FFF_FFFF);
      chk('h01, 32'h7FFF_FFFF, 0, "R8 mask top off");
      wr('h04, 32'h08);
      chk('h02, 32'h02, 0, "R7 partial clear");
      chk('h00, 32'h8000_0000, 0, "R6 bus err left");
      wr('h04, 32'h02);
      chk('h02, 32'h0, 0, "R7 cleared");
      chk('h00, 32'h0, 0, "R6 src clear");

      // R4 set wins (controller)
      drive(1'b1, 'h04, 32'h10, '0, 4'b1000);
      chk('h02, 32'h10, 0, "R4 glb set wins");
      wr('h04, 32'hFFFF_FFFF);
      chk('h02, 32'h0, 0, "R7 timer cleared");

      // R11 read-only and unmapped writes
      wr('h00, 32'hFFFF_FFFF);
      wr('h02, 32'hFFFF_FFFF);
      wr(pa(0,0), 32'hFFFF_FFFF);
      wr('h05, 32'hFFFF_FFFF);
      wr('h30, 32'hFFFF_FFFF);
      chk(pa(0,0), 32'h0, 0, "R11 p0 stat");
      chk('h02, 32'h0, 0, "R11 gstat");
      chk('h01, 32'h7FFF_FFFF, 0, "R11 mask");
      chk(pa(0,1), 32'h31, 0, "R11 p0 en");
      chk('h00, 32'h0, 0, "R11 src");

      // R8 per-bit masking on pipe 3
      drive(1'b0, 0, 0, pev(3, 6'h30), '0);
      chk(pa(3,0), 32'h30, 1, "R2 p3 err end");
      wr('h01, 32'h8);
      chk('h00, 32'h8, 1, "R8 only p3");
      wr('h01, 32'h7);
      chk('h00, 32'h8, 0, "R8 p3 masked");

      // R5 all pipes at once
      drive(1'b0, 0, 0, pev(0,6'h01) | pev(1,6'h01) | pev(2,6'h01) | pev(3,6'h01), '0);
      chk('h00, 32'hF, 1, "R5 all pipes");

      repeat (3) drive(1'b0, 0, 0, '0, '0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule